// File: doc/BRIEF.md
# Shared Issue Queue Occupancy Allocator

This block keeps track of how many issue queue entries each hardware thread holds and how many remain free in the whole queue. The queue is shared by several threads. A configuration parameter selects one of three sharing rules: every thread may use the whole queue, the queue is split evenly among the active threads, or each thread is capped at a fixed percentage of the queue. The block does not store instructions. It only grants or refuses entry allocations and counts the entries that are given back.

Entries come back in three ways. A non-memory instruction returns its entry when it issues. A memory instruction keeps its entry until its completion is reported. A squash returns a number of entries from one thread. The per-thread caps are recomputed from the active-thread mask in the same cycle the mask changes. When allocations and releases arrive in the same cycle, they are merged into a single counter update.

Top module: `smt_iq_alloc`

## Requirements
- R1: With the unrestricted policy, every thread's cap equals the total entry count, whatever the active mask is.
- R2: With the split policy, every thread's cap is the total divided by the number of set bits in the active mask, truncated. When the mask is all zero, the divisor is the thread count.
- R3: With the percentage policy, every thread's cap is total times percentage divided by 100, truncated. When exactly one thread is active, the cap is the whole queue.
- R4: A thread's free count is its cap minus its occupancy, or zero if the occupancy is at or above the cap. The thread's full flag is set exactly when that count is zero.
- R5: The global free count equals the total entries minus the sum of all thread occupancies. The global full flag is set when it is zero, and while it is set, no allocation is granted, even to a thread that still has free entries.
- R6: An issue with the memory flag low frees one entry of that thread at the next clock edge. An issue with the memory flag high leaves every count unchanged.
- R7: A completion report frees one entry of the named thread at the next clock edge.
- R8: A squash frees the given number of entries from the named thread. The number freed is limited to that thread's occupancy.
- R9: An allocation to a full thread, or while the queue is full, changes no count. The error output is high for exactly the cycle that follows the refused request and low after a granted one.
- R10: An allocation, an issue, a completion and a squash in the same cycle are combined into one update of the thread and global counts.
- R11: After reset, every occupancy is zero, the global free count equals the total, and each thread's free count equals its cap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| active_mask | input | NUM_THREADS | One bit per thread that is currently running |
| alloc_valid | input | 1 | Request to allocate one entry |
| alloc_tid | input | TW | Thread requesting the allocation |
| alloc_mem | input | 1 | Allocated instruction is a memory operation (informational) |
| alloc_grant | output | 1 | Allocation accepted this cycle |
| alloc_err | output | 1 | Pulse one cycle after a refused allocation |
| issue_valid | input | 1 | An instruction issued |
| issue_tid | input | TW | Thread of the issued instruction |
| issue_mem | input | 1 | Issued instruction is a memory operation |
| done_valid | input | 1 | A memory operation completed |
| done_tid | input | TW | Thread of the completed memory operation |
| squash_valid | input | 1 | Squash release this cycle |
| squash_tid | input | TW | Thread being squashed |
| squash_cnt | input | CW | Number of entries the squash releases |
| global_free | output | CW | Free entries in the whole queue |
| global_full | output | 1 | Global free count is zero |
| thread_free | output | NUM_THREADS*CW | Per-thread free counts, thread i at bits [i*CW +: CW] |
| thread_full | output | NUM_THREADS | Per-thread full flags |

## Verification
The hardest state to reach is a refusal that comes only from the global count while the requesting thread still has room. Under the even split, the caps add up to exactly the total, so a full queue always means the requesting thread is full as well. The bench therefore drives one stream of requests into three instances that use different policies. The unrestricted instance fills up on a request to a thread that is not full in its own view. Its error pulse and its nonzero thread free count are then checked together.

// File: rtl/smt_iq_pkg.sv
package smt_iq_pkg;
   typedef enum logic [1:0] {
      SHARE_DYNAMIC   = 2'd0,
      SHARE_PARTITION = 2'd1,
      SHARE_THRESHOLD = 2'd2
   } share_policy_e;
endpackage

// File: rtl/smt_iq_limit.sv
module smt_iq_limit #(
   parameter int NUM_THREADS = 4,
   parameter int NUM_ENTRIES = 16,
   parameter int THRESH_PCT  = 40,
   parameter smt_iq_pkg::share_policy_e POLICY = smt_iq_pkg::SHARE_PARTITION,
   localparam int CW = $clog2(NUM_ENTRIES + 1),
   localparam int AW = $clog2(NUM_THREADS + 1)
) (
   input  logic [NUM_THREADS-1:0] active_mask,
   output logic [CW-1:0]          limit
);
   localparam int THR_LIM = (NUM_ENTRIES * THRESH_PCT) / 100;

   generate
      if (POLICY == smt_iq_pkg::SHARE_DYNAMIC) begin : g_dyn
         logic unused_mask;
         assign unused_mask = ^active_mask;
         assign limit = CW'(NUM_ENTRIES);
      end else begin : g_counted
         logic [AW-1:0] active_cnt;
         always_comb begin
            active_cnt = '0;
            for (int i = 0; i < NUM_THREADS; i++)
               active_cnt = active_cnt + AW'(active_mask[i]);
         end
         if (POLICY == smt_iq_pkg::SHARE_PARTITION) begin : g_part
            always_comb begin
               limit = CW'(NUM_ENTRIES / NUM_THREADS);
               for (int k = 1; k <= NUM_THREADS; k++)
                  if (active_cnt == AW'(k)) limit = CW'(NUM_ENTRIES / k);
            end
         end else begin : g_thr
            assign limit = (active_cnt == AW'(1)) ? CW'(NUM_ENTRIES) : CW'(THR_LIM);
         end
      end
   endgenerate
endmodule

// File: rtl/smt_iq_thread_ctr.sv
module smt_iq_thread_ctr #(
   parameter int NUM_ENTRIES = 16,
   localparam int CW = $clog2(NUM_ENTRIES + 1),
   localparam int DW = CW + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] limit,
   input  logic          inc,
   input  logic          rel_issue,
   input  logic          rel_done,
   input  logic [CW-1:0] sq_cnt,
   output logic [CW-1:0] occ,
   output logic [CW-1:0] free_cnt,
   output logic          full,
   output logic [CW-1:0] applied
);
   logic [DW-1:0] sum_w, dec_w, applied_w;

   assign sum_w     = DW'(occ) + DW'(inc);
   assign dec_w     = DW'(rel_issue) + DW'(rel_done) + DW'(sq_cnt);
   assign applied_w = (dec_w > sum_w) ? sum_w : dec_w;
   assign applied   = CW'(applied_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else        occ <= CW'(sum_w - applied_w);
   end

   assign free_cnt = (limit > occ) ? (limit - occ) : '0;
   assign full     = (free_cnt == '0);
endmodule

// File: rtl/smt_iq_alloc.sv
module smt_iq_alloc #(
   parameter int NUM_THREADS = 4,
   parameter int NUM_ENTRIES = 16,
   parameter int THRESH_PCT  = 40,
   parameter smt_iq_pkg::share_policy_e POLICY = smt_iq_pkg::SHARE_PARTITION,
   localparam int CW = $clog2(NUM_ENTRIES + 1),
   localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_THREADS-1:0]    active_mask,
   input  logic                      alloc_valid,
   input  logic [TW-1:0]             alloc_tid,
   input  logic                      alloc_mem,
   output logic                      alloc_grant,
   output logic                      alloc_err,
   input  logic                      issue_valid,
   input  logic [TW-1:0]             issue_tid,
   input  logic                      issue_mem,
   input  logic                      done_valid,
   input  logic [TW-1:0]             done_tid,
   input  logic                      squash_valid,
   input  logic [TW-1:0]             squash_tid,
   input  logic [CW-1:0]             squash_cnt,
   output logic [CW-1:0]             global_free,
   output logic                      global_full,
   output logic [NUM_THREADS*CW-1:0] thread_free,
   output logic [NUM_THREADS-1:0]    thread_full
);
   localparam int GW = CW + TW + 2;

   if (NUM_THREADS < 1 || NUM_ENTRIES < NUM_THREADS) begin : g_bad_size
      $error("smt_iq_alloc: entry count must be at least the thread count");
   end
   if (THRESH_PCT < 1 || THRESH_PCT > 100 ||
       (NUM_ENTRIES * THRESH_PCT) / 100 < 1) begin : g_bad_pct
      $error("smt_iq_alloc: percentage cap must give at least one entry");
   end

   logic                      unused_alloc_mem;
   logic [CW-1:0]             limit;
   logic [NUM_THREADS*CW-1:0] occ_flat;
   logic [NUM_THREADS*CW-1:0] applied_flat;
   logic [GW-1:0]             rel_sum;
   logic [GW-1:0]             gfree_n;

   assign unused_alloc_mem = alloc_mem;

   smt_iq_limit #(
      .NUM_THREADS(NUM_THREADS), .NUM_ENTRIES(NUM_ENTRIES),
      .THRESH_PCT(THRESH_PCT), .POLICY(POLICY)
   ) u_limit (
      .active_mask(active_mask),
      .limit(limit)
   );

   assign global_full = (global_free == '0);
   assign alloc_grant = alloc_valid && !global_full &&
                        (32'(alloc_tid) < NUM_THREADS) && !thread_full[alloc_tid];

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic          inc_t, rel_issue_t, rel_done_t;
      logic [CW-1:0] sq_t;
      assign inc_t       = alloc_grant && (alloc_tid == TW'(t));
      assign rel_issue_t = issue_valid && !issue_mem && (issue_tid == TW'(t));
      assign rel_done_t  = done_valid && (done_tid == TW'(t));
      assign sq_t        = (squash_valid && (squash_tid == TW'(t))) ? squash_cnt : '0;

      smt_iq_thread_ctr #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctr (
         .clk(clk),
         .rst_n(rst_n),
         .limit(limit),
         .inc(inc_t),
         .rel_issue(rel_issue_t),
         .rel_done(rel_done_t),
         .sq_cnt(sq_t),
         .occ(occ_flat[t*CW +: CW]),
         .free_cnt(thread_free[t*CW +: CW]),
         .full(thread_full[t]),
         .applied(applied_flat[t*CW +: CW])
      );
   end

   always_comb begin
      rel_sum = '0;
      for (int t = 0; t < NUM_THREADS; t++)
         rel_sum = rel_sum + GW'(applied_flat[t*CW +: CW]);
   end

   assign gfree_n = GW'(global_free) - GW'(alloc_grant) + rel_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         global_free <= CW'(NUM_ENTRIES);
         alloc_err   <= 1'b0;
      end else begin
         global_free <= CW'(gfree_n);
         alloc_err   <= alloc_valid && !alloc_grant;
      end
   end
endmodule

// File: rtl/smt_iq_alloc_chk.sv
module smt_iq_alloc_chk #(
   parameter int NUM_THREADS = 4,
   parameter int NUM_ENTRIES = 16,
   localparam int CW = $clog2(NUM_ENTRIES + 1),
   localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      alloc_valid,
   input logic                      alloc_grant,
   input logic                      alloc_err,
   input logic                      global_full,
   input logic [CW-1:0]             global_free,
   input logic                      issue_valid,
   input logic                      issue_mem,
   input logic [TW-1:0]             issue_tid,
   input logic                      done_valid,
   input logic                      squash_valid,
   input logic [NUM_THREADS*CW-1:0] occ_flat
);
   int            occ_total;
   logic [CW-1:0] issue_occ;

   always_comb begin
      occ_total = 0;
      issue_occ = '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
         occ_total = occ_total + int'(occ_flat[t*CW +: CW]);
         if (issue_tid == TW'(t)) issue_occ = occ_flat[t*CW +: CW];
      end
   end

   assert_free_matches_occ_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(global_free) == NUM_ENTRIES - occ_total);

   assert_no_grant_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      global_full |-> !alloc_grant);

   assert_refusal_pulses_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && !alloc_grant) |=> alloc_err);

   assert_grant_clears_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && alloc_grant) |=> !alloc_err);

   assert_mem_issue_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_mem && !alloc_valid && !done_valid && !squash_valid)
      |=> $stable(global_free));

   assert_nonmem_issue_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_mem && !alloc_valid && !done_valid && !squash_valid &&
       issue_occ != '0)
      |=> (int'(global_free) == int'($past(global_free)) + 1));
endmodule

bind smt_iq_alloc smt_iq_alloc_chk #(
   .NUM_THREADS(NUM_THREADS), .NUM_ENTRIES(NUM_ENTRIES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_grant(alloc_grant),
   .alloc_err(alloc_err), .global_full(global_full), .global_free(global_free),
   .issue_valid(issue_valid), .issue_mem(issue_mem), .issue_tid(issue_tid),
   .done_valid(done_valid), .squash_valid(squash_valid), .occ_flat(occ_flat)
);

// File: tb/tb_smt_iq_alloc.sv
module tb_smt_iq_alloc;
   localparam int CLK_PERIOD = 10;
   localparam int T  = 4;
   localparam int N  = 16;
   localparam int CW = 5;
   localparam int TW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [T-1:0] active_mask = '1;
   logic alloc_valid = 0, alloc_mem = 0, issue_valid = 0, issue_mem = 0;
   logic done_valid = 0, squash_valid = 0;
   logic [TW-1:0] alloc_tid = '0, issue_tid = '0, done_tid = '0, squash_tid = '0;
   logic [CW-1:0] squash_cnt = '0;

   logic p_grant, p_err, p_gfull, d_grant, d_err, d_gfull, h_grant, h_err, h_gfull;
   logic [CW-1:0] p_gfree, d_gfree, h_gfree;
   logic [T*CW-1:0] p_tfree, d_tfree, h_tfree;
   logic [T-1:0] p_tfull, d_tfull, h_tfull;

   int nchk = 0, nfail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   smt_iq_alloc #(.NUM_THREADS(T), .NUM_ENTRIES(N), .THRESH_PCT(40),
      .POLICY(smt_iq_pkg::SHARE_PARTITION)) dut (
      .clk(clk), .rst_n(rst_n), .active_mask(active_mask),
      .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_mem(alloc_mem),
      .alloc_grant(p_grant), .alloc_err(p_err),
      .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_mem(issue_mem),
      .done_valid(done_valid), .done_tid(done_tid),
      .squash_valid(squash_valid), .squash_tid(squash_tid), .squash_cnt(squash_cnt),
      .global_free(p_gfree), .global_full(p_gfull),
      .thread_free(p_tfree), .thread_full(p_tfull));

   smt_iq_alloc #(.NUM_THREADS(T), .NUM_ENTRIES(N), .THRESH_PCT(40),
      .POLICY(smt_iq_pkg::SHARE_DYNAMIC)) dut_dyn (
      .clk(clk), .rst_n(rst_n), .active_mask(active_mask),
      .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_mem(alloc_mem),
      .alloc_grant(d_grant), .alloc_err(d_err),
      .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_mem(issue_mem),
      .done_valid(done_valid), .done_tid(done_tid),
      .squash_valid(squash_valid), .squash_tid(squash_tid), .squash_cnt(squash_cnt),
      .global_free(d_gfree), .global_full(d_gfull),
      .thread_free(d_tfree), .thread_full(d_tfull));

   smt_iq_alloc #(.NUM_THREADS(T), .NUM_ENTRIES(N), .THRESH_PCT(40),
      .POLICY(smt_iq_pkg::SHARE_THRESHOLD)) dut_thr (
      .clk(clk), .rst_n(rst_n), .active_mask(active_mask),
      .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_mem(alloc_mem),
      .alloc_grant(h_grant), .alloc_err(h_err),
      .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_mem(issue_mem),
      .done_valid(done_valid), .done_tid(done_tid),
      .squash_valid(squash_valid), .squash_tid(squash_tid), .squash_cnt(squash_cnt),
      .global_free(h_gfree), .global_full(h_gfull),
      .thread_free(h_tfree), .thread_full(h_tfull));

   function automatic int tf(input logic [T*CW-1:0] v, input int i);
      return int'(v[i*CW +: CW]);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle();
      alloc_valid = 0; issue_valid = 0; done_valid = 0; squash_valid = 0;
      alloc_mem = 0; issue_mem = 0; squash_cnt = '0;
   endtask

   task automatic alloc_one(input int tid);
      alloc_valid = 1; alloc_tid = TW'(tid);
      @(negedge clk);
      idle();
   endtask

   task automatic t_reset();
      for (int i = 0; i < T; i++) begin
         chk("R11", "part thread free", tf(p_tfree, i), 4);
         chk("R11", "dyn thread free", tf(d_tfree, i), 16);
         chk("R11", "thr thread free", tf(h_tfree, i), 6);
      end
      chk("R11", "global free", int'(p_gfree), 16);
      chk("R11", "err low", int'(p_err), 0);
   endtask

   task automatic t_limits();
      active_mask = 4'b0011; #1;
      chk("R2", "split two active", tf(p_tfree, 0), 8);
      chk("R1", "dyn two active", tf(d_tfree, 0), 16);
      chk("R3", "pct two active", tf(h_tfree, 0), 6);
      active_mask = 4'b0111; #1;
      chk("R2", "split three active", tf(p_tfree, 2), 5);
      active_mask = 4'b0001; #1;
      chk("R2", "split one active", tf(p_tfree, 0), 16);
      chk("R3", "pct one active", tf(h_tfree, 3), 16);
      active_mask = 4'b0000; #1;
      chk("R2", "split none active", tf(p_tfree, 1), 4);
      chk("R3", "pct none active", tf(h_tfree, 1), 6);
      active_mask = 4'b1111; #1;
   endtask

   task automatic t_fill();
      for (int k = 1; k <= 4; k++) begin
         alloc_one(0);
         chk("R4", "t0 free while filling", tf(p_tfree, 0), 4 - k);
         chk("R9", "no err on grant", int'(p_err), 0);
      end
      chk("R4", "t0 full flag", int'(p_tfull[0]), 1);
      alloc_one(0);
      chk("R9", "err after refusal", int'(p_err), 1);
      chk("R9", "t0 count unchanged", tf(p_tfree, 0), 0);
      chk("R9", "global unchanged", int'(p_gfree), 12);
      @(negedge clk);
      chk("R9", "err single cycle", int'(p_err), 0);
      for (int t = 1; t < T; t++)
         for (int k = 0; k < 4; k++) alloc_one(t);
      chk("R5", "global free zero", int'(p_gfree), 0);
      chk("R5", "global full", int'(p_gfull), 1);
      chk("R5", "dyn full", int'(d_gfull), 1);
      chk("R5", "dyn refused by global", int'(d_err), 1);
      chk("R5", "dyn t3 still has room", tf(d_tfree, 3), 13);
   endtask

   task automatic t_issue();
      issue_valid = 1; issue_tid = 2'd1; issue_mem = 0;
      @(negedge clk); idle();
      chk("R6", "non-mem issue t1 free", tf(p_tfree, 1), 1);
      chk("R6", "non-mem issue global", int'(p_gfree), 1);
      chk("R5", "not full after release", int'(p_gfull), 0);
      issue_valid = 1; issue_tid = 2'd2; issue_mem = 1;
      @(negedge clk); idle();
      chk("R6", "mem issue t2 free", tf(p_tfree, 2), 0);
      chk("R6", "mem issue global", int'(p_gfree), 1);
   endtask

   task automatic t_done();
      done_valid = 1; done_tid = 2'd2;
      @(negedge clk); idle();
      chk("R7", "completion t2 free", tf(p_tfree, 2), 1);
      chk("R7", "completion global", int'(p_gfree), 2);
   endtask

   task automatic t_squash();
      squash_valid = 1; squash_tid = 2'd3; squash_cnt = 5'd3;
      @(negedge clk); idle();
      chk("R8", "squash t3 free", tf(p_tfree, 3), 3);
      chk("R8", "squash global", int'(p_gfree), 5);
   endtask

   task automatic t_combined();
      alloc_valid = 1; alloc_tid = 2'd3;
      issue_valid = 1; issue_tid = 2'd3; issue_mem = 0;
      squash_valid = 1; squash_tid = 2'd0; squash_cnt = 5'd2;
      @(negedge clk); idle();
      chk("R10", "t3 alloc+issue", tf(p_tfree, 3), 3);
      chk("R10", "t0 squash", tf(p_tfree, 0), 2);
      chk("R10", "global merged", int'(p_gfree), 7);
      chk("R10", "no err", int'(p_err), 0);
   endtask

   task automatic t_limit_change();
      active_mask = 4'b0001; #1;
      chk("R4", "t1 free under larger cap", tf(p_tfree, 1), 13);
      active_mask = 4'b1111; #1;
      chk("R4", "t1 free restored", tf(p_tfree, 1), 1);
   endtask

   task automatic t_squash_clamp();
      squash_valid = 1; squash_tid = 2'd1; squash_cnt = 5'd10;
      @(negedge clk); idle();
      chk("R8", "over-squash t1 free", tf(p_tfree, 1), 4);
      chk("R8", "over-squash global", int'(p_gfree), 10);
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_limits();
      t_fill();
      t_issue();
      t_done();
      t_squash();
      t_combined();
      t_limit_change();
      t_squash_clamp();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule